// File: doc/BRIEF.md
# Counter Read Glitch Filter

This block sits between a free-running wide counter and whatever logic needs to read it. The counter's low bits cannot be trusted while a carry is passing through bit 10 or any bit above it. A sample taken in that window can jump backwards, for example 0x7FF, then 0x000, then 0x800. It can also jump forwards, for example 0x7FF, then 0xFFF, then 0x800. The filter rejects any sample whose low ten bits are all zeros or all ones. The same test can be written as ((value + 1) mod 1024) being 0 or 1.

A read is a two-phase stream transaction. The reader offers a request with `req_valid_i` / `req_ready_o`. The filter then takes one counter sample per clock until it gets an acceptable one, and presents that sample on `rsp_data_o` with `rsp_valid_o` / `rsp_ready_i`. The reader may hold `rsp_ready_i` low for any number of cycles. Until it accepts, the response and its data stay frozen and no new request is taken.

The number of samples per read is bounded by `MAX_TRIES`, which defaults to 150, about three periods of a 24 MHz counter seen from a fast clock. When that bound runs out, the last sample is returned anyway and a sticky warning flag is raised. A derived output gives a compare value minus the returned count as a 32-bit difference, for reads of time remaining.

Top module: `cnt_glitch_filter`

## Requirements
- R1: A sample whose low ten bits are neither 0x000 nor 0x3FF is accepted. When the first sample after a request is acceptable, it is the value returned.
- R2: A sample whose low ten bits are 0x000 or 0x3FF is never returned while the retry bound still allows another sample. Samples are taken one per clock, starting the cycle after the request is accepted. `rsp_valid_o` rises the cycle after the accepted sample, so the latency is (number of rejected samples + 1).
- R3: At most `MAX_TRIES` samples are taken per read. If all of them are rejected, the last sample taken is returned after exactly `MAX_TRIES` sampling cycles.
- R4: `warn_o` rises when a read exhausts its retry bound. It then stays high through later successful reads until `warn_clr_i` is pulsed or reset is applied. A clear pulse drops it on the next cycle.
- R5: `req_ready_o` is high only when no read is in progress. It is low from the cycle after a request is accepted until the cycle after the response handshake.
- R6: While `rsp_valid_o` is high and `rsp_ready_i` is low, `rsp_valid_o` stays high and `rsp_data_o` stays unchanged, even if the counter moves.
- R7: `tval_o` equals `cmp_i[31:0] - rsp_data_o[31:0]` modulo 2^32.
- R8: After reset, `req_ready_o` is 1, `rsp_valid_o` is 0 and `warn_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | CNT_W | Free-running counter being read |
| req_valid_i | input | 1 | Read request offered |
| req_ready_o | output | 1 | Filter idle, request will be taken |
| rsp_valid_o | output | 1 | Filtered sample available |
| rsp_ready_i | input | 1 | Reader accepts the response |
| rsp_data_o | output | CNT_W | Filtered counter sample |
| cmp_i | input | CNT_W | Compare value for the difference output |
| tval_o | output | 32 | cmp_i minus rsp_data_o, low 32 bits |
| warn_o | output | 1 | Sticky retry-exhausted flag |
| warn_clr_i | input | 1 | Clears warn_o |

## Verification
The hardest situation to reach from the ports is a run of rejected samples that ends exactly at, one short of, or past the retry bound. A real counter only produces that during a carry, which is rare. The bench therefore drives the counter input itself, one value per clock. It scripts 0 to MAX_TRIES rejected samples, alternating all-zero and all-one low fields, before a good value. It also sweeps every one of the 1024 low-field patterns as a constant counter, so that both rejection patterns exhaust the bound and every other pattern passes on the first sample.

// File: rtl/cgf_pkg.sv
package cgf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAMP = 2'd1,
    ST_RESP = 2'd2
  } cgf_state_e;
endpackage

// File: rtl/cgf_judge.sv
// Flags a sample taken while a carry may be crossing the guarded field.
module cgf_judge #(
  parameter int CNT_W = 64,
  parameter int LOW_W = 10
) (
  input  logic [CNT_W-1:0] smp_i,
  output logic             reject_o
);
  logic [LOW_W-1:0] low_plus1;

  // all-ones wraps to 0, all-zeros becomes 1
  assign low_plus1 = smp_i[LOW_W-1:0] + LOW_W'(1);
  assign reject_o  = (low_plus1 <= LOW_W'(1));
endmodule

// File: rtl/cgf_seq.sv
module cgf_seq
  import cgf_pkg::*;
#(
  parameter int MAX_TRIES = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid_i,
  output logic req_ready_o,
  output logic rsp_valid_o,
  input  logic rsp_ready_i,
  input  logic reject_i,
  output logic capture_o,
  output logic give_up_o
);
  localparam int TRY_W = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;

  cgf_state_e       state;
  logic [TRY_W-1:0] tries;
  logic             last_try;

  assign last_try    = (tries == TRY_W'(MAX_TRIES - 1));
  assign capture_o   = (state == ST_SAMP) && (!reject_i || last_try);
  assign give_up_o   = (state == ST_SAMP) && reject_i && last_try;
  assign req_ready_o = (state == ST_IDLE);
  assign rsp_valid_o = (state == ST_RESP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      tries <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid_i) begin
          state <= ST_SAMP;
          tries <= '0;
        end
        ST_SAMP: if (capture_o) state <= ST_RESP;
                 else           tries <= tries + TRY_W'(1);
        ST_RESP: if (rsp_ready_i) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r3_try_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SAMP) |-> (tries <= TRY_W'(MAX_TRIES - 1)));
endmodule

// File: rtl/cgf_warn.sv
module cgf_warn (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic warn_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     warn_o <= 1'b0;
    else if (set_i) warn_o <= 1'b1;
    else if (clr_i) warn_o <= 1'b0;
  end

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_o && !clr_i) |=> warn_o);
endmodule

// File: rtl/cnt_glitch_filter.sv
module cnt_glitch_filter #(
  parameter int CNT_W     = 64,
  parameter int LOW_W     = 10,
  parameter int MAX_TRIES = 150,
  parameter int TVAL_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [CNT_W-1:0]  rsp_data_o,
  input  logic [CNT_W-1:0]  cmp_i,
  output logic [TVAL_W-1:0] tval_o,
  output logic              warn_o,
  input  logic              warn_clr_i
);
  logic reject, capture, give_up;
  logic [CNT_W-1:0] held;

  cgf_judge #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_judge (
    .smp_i(cnt_i), .reject_o(reject));

  cgf_seq #(.MAX_TRIES(MAX_TRIES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i),
    .reject_i(reject), .capture_o(capture), .give_up_o(give_up));

  cgf_warn u_warn (
    .clk(clk), .rst_n(rst_n), .set_i(give_up), .clr_i(warn_clr_i),
    .warn_o(warn_o));

  always_ff @(posedge clk) begin
    if (!rst_n)       held <= '0;
    else if (capture) held <= cnt_i;
  end

  assign rsp_data_o = held;
  assign tval_o     = cmp_i[TVAL_W-1:0] - held[TVAL_W-1:0];

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o)));

  a_r5_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> !req_ready_o);

  a_r2_clean: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid_o) && !$past(give_up)) |->
      (rsp_data_o[LOW_W-1:0] != '0 && rsp_data_o[LOW_W-1:0] != '1));

  a_r4_raise: assert property (@(posedge clk) disable iff (!rst_n)
    give_up |=> warn_o);
endmodule

// File: tb/test_cnt_glitch_filter.sv
module test_cnt_glitch_filter;
  localparam int MT = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b1;
  logic [63:0] rsp_data_o;
  logic [63:0] cmp_i = '0;
  logic [31:0] tval_o;
  logic        warn_o;
  logic        warn_clr_i = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] seqv [0:15];

  always #2 clk = ~clk;

  cnt_glitch_filter #(.MAX_TRIES(MT)) i_cnt_glitch_filter (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i),
    .rsp_data_o(rsp_data_o), .cmp_i(cmp_i), .tval_o(tval_o),
    .warn_o(warn_o), .warn_clr_i(warn_clr_i));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue a read; the counter follows seqv, one entry per clock.
  task automatic do_read(output int lat, output logic [63:0] data);
    int i;
    @(negedge clk);
    chk("R5 ready when idle", {63'd0, req_ready_o}, 64'd1);
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    i = 0;
    while (!rsp_valid_o && i < 40) begin
      if (i > 0) chk("R5 busy while sampling", {63'd0, req_ready_o}, 64'd0);
      cnt_i = seqv[(i < 16) ? i : 15];
      @(negedge clk);
      i++;
    end
    lat  = i;
    data = rsp_data_o;
    chk("R7 tval", {32'd0, tval_o}, {32'd0, cmp_i[31:0] - data[31:0]});
  endtask

  task automatic finish_rsp();
    @(negedge clk);
    chk("R5 ready after handshake", {63'd0, req_ready_o}, 64'd1);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat;
    logic [63:0] d, v, good, expd;
    int explat;
    logic expw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset req_ready", {63'd0, req_ready_o}, 64'd1);
    chk("R8 reset rsp_valid", {63'd0, rsp_valid_o}, 64'd0);
    chk("R8 reset warn", {63'd0, warn_o}, 64'd0);

    // Sweep all low-field patterns with a constant counter
    for (int lo = 0; lo < 1024; lo++) begin
      v = {32'hA5000000 ^ (32'(lo) * 32'h9E3779B1), 22'(lo * 7), 10'(lo)};
      cmp_i = v + 64'(lo * 37) - 64'd5;
      for (int k = 0; k < 16; k++) seqv[k] = v;
      do_read(lat, d);
      if (lo == 0 || lo == 1023) begin
        chk("R3 exhausted latency", 64'(lat), 64'(MT));
        chk("R3 last sample returned", d, v);
        chk("R4 warn raised", {63'd0, warn_o}, 64'd1);
      end else begin
        chk("R1 first sample accepted latency", 64'(lat), 64'd1);
        chk("R1 data", d, v);
      end
      finish_rsp();
      if (warn_o) begin
        warn_clr_i = 1'b1;
        @(negedge clk);
        warn_clr_i = 1'b0;
        chk("R4 clear", {63'd0, warn_o}, 64'd0);
      end
    end

    // Scripted runs of rejected samples before a good one
    for (int nb = 0; nb <= MT + 1; nb++) begin
      good = 64'h0000_1234_5678_0123 + 64'(nb);
      for (int k = 0; k < 16; k++)
        seqv[k] = (k < nb) ? ((k % 2 == 0) ? 64'h0000_1234_5678_03FF
                                           : 64'h0000_1234_5678_0400)
                           : good;
      explat = (nb < MT) ? nb + 1 : MT;
      expd   = (nb < MT) ? good : seqv[MT-1];
      expw   = (nb >= MT);
      cmp_i  = 64'h0000_0000_0000_0010;
      do_read(lat, d);
      chk("R2 latency = rejects+1", 64'(lat), 64'(explat));
      chk("R2 data after rejects", d, expd);
      chk("R4 warn after run", {63'd0, warn_o}, {63'd0, expw});
      finish_rsp();
    end

    // Warn stays through a good read
    for (int k = 0; k < 16; k++) seqv[k] = 64'h55;
    do_read(lat, d);
    chk("R4 sticky over good read", {63'd0, warn_o}, 64'd1);
    finish_rsp();
    warn_clr_i = 1'b1;
    @(negedge clk);
    warn_clr_i = 1'b0;
    chk("R4 clear pulse", {63'd0, warn_o}, 64'd0);

    // Back-pressure
    rsp_ready_i = 1'b0;
    for (int k = 0; k < 16; k++) seqv[k] = 64'hBEEF_0000_0000_0201;
    do_read(lat, d);
    for (int c = 0; c < 4; c++) begin
      cnt_i = 64'(c * 513 + 77);
      @(negedge clk);
      chk("R6 valid held", {63'd0, rsp_valid_o}, 64'd1);
      chk("R6 data held", rsp_data_o, 64'hBEEF_0000_0000_0201);
      chk("R5 no new request", {63'd0, req_ready_o}, 64'd0);
    end
    rsp_ready_i = 1'b1;
    finish_rsp();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule